// File: doc/BRIEF.md
# Ethernet Receive Frame Parser with Address Filter

This block sits behind a Manchester decoder and turns its recovered serial NRZ stream into whole Ethernet frames. Each cycle in which the carrier qualifier is high, the decoder presents one bit. The parser first hunts for the start-of-frame delimiter. It then packs the following bits into bytes, least significant bit first, and reads the first six bytes as the destination address.

The destination address is checked against a programmed individual address and against the broadcast address. A promiscuous enable bypasses the check. Frames that pass are sent on a byte stream. The first byte carries a start marker, and a separate end-marker cycle follows the last byte. The end-marker cycle carries three status flags: CRC error, runt and dribble. Frames that fail the check leave no trace on the outputs. A configuration bit selects whether the four trailing FCS bytes are delivered or stripped. Because the FCS is only known once the carrier falls, bytes pass through a short holding buffer before they are delivered.

Top module: `eth_rx_parser`

## Requirements
- R1: A frame starts only after the last eight bits received under carrier were 1,0,1,0,1,0,1,1 in arrival order. Every later bit is frame data, packed into bytes with the first-arriving bit in bit 0.
- R2: If the carrier drops before the delimiter is complete, the bits seen so far are discarded, so a pattern split across a carrier gap never starts a frame.
- R3: The first six frame bytes form the destination address. The frame is accepted when they equal `cfg_ucast_addr`, with bits [47:40] being the first byte on the wire. It is also accepted when all six bytes are 8'hFF, or when `cfg_promisc` is 1.
- R4: A rejected frame produces no byte, no start marker and no end marker. This includes a frame that ends before six bytes arrive.
- R5: An accepted frame is delivered byte by byte in arrival order. `out_sof` is set with the first byte, and `out_eof` is set on its own cycle, without `out_valid`, after the last byte.
- R6: With `cfg_keep_fcs` = 1, the four FCS bytes are delivered as the final bytes. With 0, they are withheld and all earlier bytes are still delivered.
- R7: `out_crc_err` is 1 on the end-marker cycle when CRC-32 (polynomial 0x04C11DB7, initial value all ones, bits fed in arrival order) over all bytes from the destination address through the FCS does not leave the residue 0xC704DD7B.
- R8: `out_runt` is 1 on the end-marker cycle when the frame held fewer than 64 whole bytes, FCS included. A frame of exactly 64 bytes is not a runt.
- R9: When the carrier drops with 1 to 7 bits of an unfinished byte, those bits are discarded and kept out of the CRC, and `out_dribble` is 1 on the end-marker cycle.
- R10: After reset and on every cycle other than an end-marker cycle, the three status flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_crs | input | 1 | Carrier qualifier; rx_bit is valid while high |
| rx_bit | input | 1 | Serial NRZ data bit |
| cfg_ucast_addr | input | 8*DA_BYTES | Individual address to accept |
| cfg_promisc | input | 1 | Accept every destination address |
| cfg_keep_fcs | input | 1 | Deliver the FCS bytes with the frame |
| out_valid | output | 1 | out_data holds a frame byte |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | End-marker cycle carrying status |
| out_crc_err | output | 1 | FCS check failed |
| out_runt | output | 1 | Frame shorter than the minimum |
| out_dribble | output | 1 | Trailing partial byte was dropped |

## Verification
Frames are driven with a unicast match, with broadcast, with a foreign address both with and without promiscuous mode, and with an address that differs only in its last byte. These cases separate each leg of the filter. Frame sizes of 63 and 64 bytes locate the runt threshold. A corrupted payload byte and a frame with three trailing bits separate the CRC-error and dribble flags, and the dribble case also shows that partial bits stay out of the CRC. A delimiter split by a carrier gap and a four-byte frame confirm that no output appears in either case. Running the same frames with and without FCS delivery shows that stripping removes exactly the last four bytes.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam int          FCS_BYTES   = 4;
  localparam logic [7:0]  SFD_PATTERN = 8'hD5;
  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  typedef enum logic {DF_HUNT, DF_FRAME} dfr_state_t;
  typedef enum logic {CT_RUN, CT_DRAIN} ctl_state_t;

  typedef struct packed {
    logic crc_err;
    logic runt;
    logic dribble;
  } end_flags_t;
endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       crs,
  input  logic       din,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       sfd_evt,
  output logic       end_evt,
  output logic       end_partial
);
  dfr_state_t st;
  logic [7:0] sh;
  logic [2:0] bcnt;
  logic [7:0] sh_nx;

  assign sh_nx = {din, sh[7:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= DF_HUNT;
      sh          <= '0;
      bcnt        <= '0;
      byte_vld    <= 1'b0;
      byte_data   <= '0;
      sfd_evt     <= 1'b0;
      end_evt     <= 1'b0;
      end_partial <= 1'b0;
    end else begin
      byte_vld    <= 1'b0;
      sfd_evt     <= 1'b0;
      end_evt     <= 1'b0;
      end_partial <= 1'b0;
      case (st)
        DF_HUNT: begin
          if (crs) begin
            sh <= sh_nx;
            if (sh_nx == SFD_PATTERN) begin
              st      <= DF_FRAME;
              bcnt    <= '0;
              sfd_evt <= 1'b1;
            end
          end else begin
            sh <= '0;
          end
        end
        default: begin
          if (crs) begin
            sh   <= sh_nx;
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              byte_vld  <= 1'b1;
              byte_data <= sh_nx;
            end
          end else begin
            st          <= DF_HUNT;
            sh          <= '0;
            bcnt        <= '0;
            end_evt     <= 1'b1;
            end_partial <= (bcnt != 3'd0);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_crc32_chk.sv
module rx_crc32_chk
  import eth_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  output logic       crc_ok
);
  logic [31:0] crc;
  logic [31:0] crc_nx;

  always_comb begin
    crc_nx = crc;
    for (int i = 0; i < 8; i++) begin
      if (crc_nx[31] ^ byte_data[i]) crc_nx = {crc_nx[30:0], 1'b0} ^ CRC_POLY;
      else                           crc_nx = {crc_nx[30:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    crc <= '1;
    else if (byte_vld) crc <= crc_nx;
  end

  assign crc_ok = (crc == CRC_RESIDUE);
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int DA_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  byte_vld,
  input  logic [7:0]            byte_data,
  input  logic [8*DA_BYTES-1:0] addr,
  input  logic                  promisc,
  output logic                  accept
);
  localparam int IW = $clog2(DA_BYTES + 1);

  logic [IW-1:0] idx;
  logic          uc_eq;
  logic          bc_eq;
  logic          decided;
  logic [7:0]    exp_byte;

  assign decided = (idx == IW'(DA_BYTES));

  always_comb begin
    exp_byte = '0;
    for (int i = 0; i < DA_BYTES; i++) begin
      if (idx == IW'(i)) exp_byte = addr[8*(DA_BYTES-1-i) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx   <= '0;
      uc_eq <= 1'b1;
      bc_eq <= 1'b1;
    end else if (byte_vld && !decided) begin
      uc_eq <= uc_eq & (byte_data == exp_byte);
      bc_eq <= bc_eq & (&byte_data);
      idx   <= idx + IW'(1);
    end
  end

  assign accept = decided & (uc_eq | bc_eq | promisc);
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [W-1:0]              wdata,
  input  logic                      rd,
  output logic [W-1:0]              rdata,
  output logic [$clog2(DEPTH):0]    count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr) wp <= wp + AW'(1);
      if (rd) rp <= rp + AW'(1);
      count <= count + (AW+1)'(wr) - (AW+1)'(rd);
    end
  end

  assign rdata = mem[rp];
endmodule

// File: rtl/eth_rx_parser.sv
module eth_rx_parser
  import eth_rx_pkg::*;
#(
  parameter int DA_BYTES  = 6,
  parameter int MIN_FRAME = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rx_crs,
  input  logic                  rx_bit,
  input  logic [8*DA_BYTES-1:0] cfg_ucast_addr,
  input  logic                  cfg_promisc,
  input  logic                  cfg_keep_fcs,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  out_sof,
  output logic                  out_eof,
  output logic                  out_crc_err,
  output logic                  out_runt,
  output logic                  out_dribble
);
  localparam int HOLD  = (DA_BYTES > FCS_BYTES) ? DA_BYTES : FCS_BYTES;
  localparam int DEPTH = 1 << $clog2(HOLD);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(MIN_FRAME + 1);

  logic       byte_vld;
  logic [7:0] byte_data;
  logic       sfd_evt;
  logic       end_evt;
  logic       end_partial;
  logic       crc_ok;
  logic       accept;

  logic          fifo_clr;
  logic          pop;
  logic          emit;
  logic [7:0]    fifo_rdata;
  logic [AW:0]   fifo_cnt;
  logic          fifo_full;

  ctl_state_t  st;
  logic        in_drain;
  logic [AW:0] drain_left;
  end_flags_t  flags_q;
  logic        sof_pend;
  logic [CW-1:0] byte_cnt;

  rx_deframer u_deframer (
    .clk(clk), .rst(rst), .crs(rx_crs), .din(rx_bit),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .sfd_evt(sfd_evt), .end_evt(end_evt), .end_partial(end_partial)
  );

  rx_crc32_chk u_crc (
    .clk(clk), .rst(rst), .clr(sfd_evt),
    .byte_vld(byte_vld), .byte_data(byte_data), .crc_ok(crc_ok)
  );

  rx_da_filter #(.DA_BYTES(DA_BYTES)) u_filter (
    .clk(clk), .rst(rst), .clr(sfd_evt),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .addr(cfg_ucast_addr), .promisc(cfg_promisc), .accept(accept)
  );

  rx_hold_buf #(.W(8), .DEPTH(DEPTH)) u_hold (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .wr(byte_vld), .wdata(byte_data), .rd(pop),
    .rdata(fifo_rdata), .count(fifo_cnt)
  );

  assign in_drain  = (st == CT_DRAIN);
  assign fifo_full = (fifo_cnt == (AW+1)'(HOLD));

  always_comb begin
    if (in_drain) begin
      pop  = (drain_left != '0);
      emit = pop;
    end else begin
      pop  = byte_vld & fifo_full;
      emit = pop & accept;
    end
  end

  assign fifo_clr = sfd_evt
                  | (!in_drain & end_evt & !accept)
                  | (in_drain & (drain_left == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= CT_RUN;
      drain_left  <= '0;
      flags_q     <= '0;
      sof_pend    <= 1'b0;
      byte_cnt    <= '0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sof     <= 1'b0;
      out_eof     <= 1'b0;
      out_crc_err <= 1'b0;
      out_runt    <= 1'b0;
      out_dribble <= 1'b0;
    end else begin
      out_valid   <= emit;
      out_data    <= emit ? fifo_rdata : 8'h00;
      out_sof     <= emit & sof_pend;
      out_eof     <= 1'b0;
      out_crc_err <= 1'b0;
      out_runt    <= 1'b0;
      out_dribble <= 1'b0;
      if (emit) sof_pend <= 1'b0;
      if (!in_drain) begin
        if (sfd_evt) begin
          byte_cnt <= '0;
          sof_pend <= 1'b1;
        end
        if (byte_vld && byte_cnt != CW'(MIN_FRAME)) byte_cnt <= byte_cnt + CW'(1);
        if (end_evt && accept) begin
          st         <= CT_DRAIN;
          drain_left <= cfg_keep_fcs ? fifo_cnt : fifo_cnt - (AW+1)'(FCS_BYTES);
          flags_q    <= '{crc_err: !crc_ok,
                          runt:    (byte_cnt < CW'(MIN_FRAME)),
                          dribble: end_partial};
        end
      end else begin
        if (drain_left != '0) begin
          drain_left <= drain_left - (AW+1)'(1);
        end else begin
          st          <= CT_RUN;
          out_eof     <= 1'b1;
          out_crc_err <= flags_q.crc_err;
          out_runt    <= flags_q.runt;
          out_dribble <= flags_q.dribble;
        end
      end
    end
  end
endmodule

// File: rtl/eth_rx_parser_chk.sv
module eth_rx_parser_chk #(
  parameter int CW   = 4,
  parameter int HOLD = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          out_valid,
  input logic          out_sof,
  input logic          out_eof,
  input logic          out_crc_err,
  input logic          out_runt,
  input logic          out_dribble,
  input logic          sfd_evt,
  input logic          in_drain,
  input logic [CW-1:0] fifo_cnt
);
  logic in_pkt;

  always_ff @(posedge clk) begin
    if (rst)          in_pkt <= 1'b0;
    else if (out_sof) in_pkt <= 1'b1;
    else if (out_eof) in_pkt <= 1'b0;
  end

  AST_SOF_HAS_BYTE: assert property (@(posedge clk) disable iff (rst) out_sof |-> out_valid); // R5
  AST_EOF_OWN_CYCLE: assert property (@(posedge clk) disable iff (rst) out_eof |-> !out_valid); // R5
  AST_EOF_CLOSES_OPEN: assert property (@(posedge clk) disable iff (rst) out_eof |-> in_pkt); // R5
  AST_SOF_NOT_NESTED: assert property (@(posedge clk) disable iff (rst) out_sof |-> !in_pkt); // R5
  AST_BYTE_IN_PACKET: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_sof) |-> in_pkt); // R4
  AST_FLAGS_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst) !out_eof |-> !(out_crc_err || out_runt || out_dribble)); // R10
  AST_NO_START_IN_DRAIN: assert property (@(posedge clk) disable iff (rst) in_drain |-> !sfd_evt); // R1
  AST_HOLD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) fifo_cnt <= CW'(HOLD)); // R6
endmodule

bind eth_rx_parser eth_rx_parser_chk #(.CW(AW+1), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst(rst),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .out_crc_err(out_crc_err), .out_runt(out_runt), .out_dribble(out_dribble),
  .sfd_evt(sfd_evt), .in_drain(in_drain), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_eth_rx_parser.sv
`timescale 1ns/1ps
module tb_eth_rx_parser;
  typedef logic [7:0] bq_t[$];
  typedef struct {
    bit         eof;
    bit         sof;
    logic [7:0] data;
    logic [2:0] flags;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_crs = 1'b0;
  logic        rx_bit = 1'b0;
  logic [47:0] cfg_ucast_addr = 48'h0A1B2C3D4E5F;
  logic        cfg_promisc = 1'b0;
  logic        cfg_keep_fcs = 1'b0;
  logic        out_valid, out_sof, out_eof, out_crc_err, out_runt, out_dribble;
  logic [7:0]  out_data;

  int   n_chk = 0;
  int   n_fail = 0;
  int   ev_cnt = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  eth_rx_parser dut (
    .clk(clk), .rst(rst), .rx_crs(rx_crs), .rx_bit(rx_bit),
    .cfg_ucast_addr(cfg_ucast_addr), .cfg_promisc(cfg_promisc),
    .cfg_keep_fcs(cfg_keep_fcs), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_crc_err(out_crc_err),
    .out_runt(out_runt), .out_dribble(out_dribble)
  );

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (out_valid || out_eof)) begin
      ev_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected output", {out_valid, out_eof}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (out_valid) begin
          chk(!e.eof, e.tag, "byte where end expected", 1, 0);
          chk(out_data == e.data, e.tag, "data", out_data, e.data);
          chk(out_sof == e.sof, e.tag, "sof", out_sof, e.sof);
          chk({out_crc_err, out_runt, out_dribble} == 3'b000, "R10", "flags on byte",
              {out_crc_err, out_runt, out_dribble}, 0);
        end else begin
          chk(e.eof, e.tag, "end where byte expected", 1, 0);
          chk({out_crc_err, out_runt, out_dribble} == e.flags, e.tag, "end flags",
              {out_crc_err, out_runt, out_dribble}, e.flags);
        end
      end
    end
  end

  task automatic drive_bit(logic b);
    @(negedge clk);
    rx_crs = 1'b1;
    rx_bit = b;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      rx_crs = 1'b0;
      rx_bit = 1'b0;
    end
  endtask

  task automatic drive_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) drive_bit(v[i]);
  endtask

  function automatic logic [31:0] crc_of(bq_t b);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int k = 0; k < b.size(); k++) begin
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ b[k][i];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic bq_t make_body(logic [47:0] da, int plen);
    bq_t q;
    for (int i = 0; i < 6; i++) q.push_back(da[8*(5-i) +: 8]);
    for (int i = 0; i < 6; i++) q.push_back(8'h20 + 8'(i));
    q.push_back(8'(plen >> 8));
    q.push_back(8'(plen));
    for (int i = 0; i < plen; i++) q.push_back(8'(i * 7 + 3));
    return q;
  endfunction

  function automatic bq_t add_fcs(bq_t body);
    bq_t q;
    logic [31:0] f;
    logic [7:0] v;
    q = body;
    f = ~crc_of(body);
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < 8; i++) v[i] = f[31 - (8*j + i)];
      q.push_back(v);
    end
    return q;
  endfunction

  task automatic send_frame(bq_t body, int extra_bits, bit corrupt, string tag);
    bq_t full;
    logic [47:0] da;
    bit acc;
    int nout;
    exp_t e;
    full = add_fcs(body);
    if (corrupt) full[body.size()-1] = full[body.size()-1] ^ 8'h01;
    for (int i = 0; i < 6; i++) da[8*(5-i) +: 8] = full[i];
    acc = (da == cfg_ucast_addr) || (da == '1) || cfg_promisc;
    if (acc) begin
      nout = cfg_keep_fcs ? full.size() : full.size() - 4;
      for (int i = 0; i < nout; i++) begin
        e.eof = 1'b0; e.sof = (i == 0); e.data = full[i]; e.flags = 3'b000; e.tag = tag;
        exp_q.push_back(e);
      end
      e.eof = 1'b1; e.sof = 1'b0; e.data = 8'h00; e.tag = tag;
      e.flags = {corrupt, (full.size() < 64), (extra_bits > 0)};
      exp_q.push_back(e);
    end
    for (int i = 0; i < 7; i++) drive_byte(8'h55);
    drive_byte(8'hD5);
    for (int i = 0; i < full.size(); i++) drive_byte(full[i]);
    for (int i = 0; i < extra_bits; i++) drive_bit(i[0]);
    idle(16);
  endtask

  initial begin
    int ev0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: quiet after reset
    chk({out_valid, out_eof, out_sof} == 3'b000, "R5", "outputs after reset",
        {out_valid, out_eof, out_sof}, 0);
    chk({out_crc_err, out_runt, out_dribble} == 3'b000, "R10", "flags after reset",
        {out_crc_err, out_runt, out_dribble}, 0);
    idle(4);

    // R1 R3 R5 R6 R8: unicast, FCS stripped, exactly 64 bytes
    send_frame(make_body(cfg_ucast_addr, 46), 0, 1'b0, "R6");
    // R3 R6: broadcast with FCS delivered
    cfg_keep_fcs = 1'b1;
    send_frame(make_body('1, 46), 0, 1'b0, "R3");
    cfg_keep_fcs = 1'b0;

    // R4: foreign address rejected
    ev0 = ev_cnt;
    send_frame(make_body(48'h112233445566, 46), 0, 1'b0, "R4");
    chk(ev_cnt == ev0, "R4", "output from foreign address", ev_cnt - ev0, 0);
    // R4: last address byte differs
    ev0 = ev_cnt;
    send_frame(make_body(cfg_ucast_addr ^ 48'h1, 46), 0, 1'b0, "R4");
    chk(ev_cnt == ev0, "R4", "output from near-miss address", ev_cnt - ev0, 0);

    // R3: promiscuous accepts foreign address
    cfg_promisc = 1'b1;
    send_frame(make_body(48'h112233445566, 30), 0, 1'b0, "R3");
    cfg_promisc = 1'b0;

    // R8: 63-byte runt and a short runt with FCS delivered
    send_frame(make_body(cfg_ucast_addr, 45), 0, 1'b0, "R8");
    cfg_keep_fcs = 1'b1;
    send_frame(make_body(cfg_ucast_addr, 2), 0, 1'b0, "R8");
    cfg_keep_fcs = 1'b0;

    // R7: corrupted payload
    send_frame(make_body(cfg_ucast_addr, 50), 0, 1'b1, "R7");
    // R9: three trailing bits, CRC still good
    send_frame(make_body('1, 46), 3, 1'b0, "R9");

    // R2: delimiter split by carrier gap, then a broadcast frame
    ev0 = ev_cnt;
    begin
      bq_t f;
      f = add_fcs(make_body('1, 46));
      for (int i = 0; i < 7; i++) drive_bit(~i[0]);
      idle(2);
      drive_bit(1'b1);
      for (int i = 0; i < f.size(); i++) drive_byte(f[i]);
      idle(16);
    end
    chk(ev_cnt == ev0, "R2", "frame after split delimiter", ev_cnt - ev0, 0);

    // R4: frame ends after four address bytes
    ev0 = ev_cnt;
    for (int i = 0; i < 7; i++) drive_byte(8'h55);
    drive_byte(8'hD5);
    for (int i = 0; i < 4; i++) drive_byte(8'hFF);
    idle(16);
    chk(ev_cnt == ev0, "R4", "output from short frame", ev_cnt - ev0, 0);

    // R1: long preamble still delivers a frame
    for (int i = 0; i < 3; i++) drive_byte(8'h55);
    send_frame(make_body(cfg_ucast_addr, 46), 0, 1'b0, "R1");

    idle(20);
    chk(exp_q.size() == 0, "R5", "expected items left undelivered", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule